// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Register

This block is the entry stage of a 4-bit-wide first-in first-out buffer. It accepts one word at a time. The word arrives either all at once on a parallel bus while a load level is held HIGH, or one bit at a time on falling edges of a slow serial clock. It keeps the word until the storage stack behind it takes the word. It also reports when it holds a complete word.

Completion is tracked by a marker bit rather than by a counter. After initialization the most significant data stage holds a single 1 and a fifth stage, the completion stage, holds 0. Each serial shift moves the chain one place toward the completion stage. After a word's worth of shifts the marker lands in the completion stage, and the active-low full output drops. A parallel load sets the completion stage directly. The handoff to the stack uses an active-low transfer request. When the request is LOW, the register is full and the stack reports a free top location, the block issues a one-cycle write strobe with the word. A transfer-done flop then blocks a second write of the same word. That flop also delays re-initialization until the load input is LOW. If the full output is wired back to the transfer input, words move into the stack without any other control.

The serial clock may be asynchronous. It passes through a synchronizer, and the block acts on its falling edges detected in the system clock domain. The load, enable, serial data and transfer inputs are treated as synchronous to the system clock.

Top module: `sp_entry_reg`

## Requirements
- R1: A synchronous active-high reset, asserted at any time, discards any partial word. One cycle later full_n_o is 1, stk_wr_o is 0 and stk_data_o is 0. A later serial word is then assembled from scratch.
- R2: A cycle with load_i HIGH captures par_d_i as the word. full_n_o is 0 after that clock edge.
- R3: Each qualified falling edge of ser_clk_i shifts ser_d_i into the top data stage. The chain moves toward bit 0 and then into the completion stage. The first bit received ends in word bit 0 and the fourth in word bit 3. After the fourth edge, full_n_o is 0.
- R4: Falling edges of ser_clk_i while ser_en_n_i is 1 do not shift the register.
- R5: Once the register is full, further serial clock edges leave the word unchanged.
- R6: After fewer than four qualified falling edges, full_n_o stays 1.
- R7: In a cycle where xfer_n_i is 0, the register is full, stk_top_empty_i is 1 and the word has not already been transferred, stk_wr_o is 1 in the next cycle for exactly one cycle. stk_data_o then carries the word.
- R8: While stk_top_empty_i is 0, no write strobe is issued. The write follows one cycle after the top location becomes empty.
- R9: A word is written at most once, even when xfer_n_i stays 0 and full_n_o stays 0 afterwards.
- R10: After a write, the register re-initializes in the first cycle where load_i is 0. full_n_o stays 0 while load_i is held HIGH and returns to 1 one cycle after load_i is 0.
- R11: With xfer_n_i driven from full_n_o, every word entered, parallel or serial, produces exactly one write strobe, and the register re-arms by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| load_i | input | 1 | Parallel load level, active HIGH |
| par_d_i | input | 4 | Parallel data word |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous, falling edge active |
| ser_en_n_i | input | 1 | Serial shift enable, active LOW |
| ser_d_i | input | 1 | Serial data bit |
| xfer_n_i | input | 1 | Transfer-to-stack request, active LOW |
| stk_top_empty_i | input | 1 | Stack top location is free |
| full_n_o | output | 1 | Register full, active LOW |
| stk_wr_o | output | 1 | One-cycle write strobe to the stack |
| stk_data_o | output | 4 | Word presented with the write strobe |

## Verification
The bench holds the transfer request LOW for many cycles and counts strobes. A design that lacks the transfer-done guard would write the same word into the stack again and again. It keeps load HIGH after a write to check that re-arming waits: a design that re-initialized early would raise full_n_o while the load is still active. It clocks extra serial bits into a full register and gated-off bits into an empty one. A design that kept shifting would present a corrupted word or report full too early. It also resets in the middle of a serial word, where a design that kept the stale marker position would report full after the wrong number of bits.

// File: rtl/sp_entry_pkg.sv
`timescale 1ns/1ps
package sp_entry_pkg;

    // Action applied to the marker/data chain in one cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INIT  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_SHIFT = 2'd3
    } reg_act_e;

    // Priority: reset, parallel load, re-arm after transfer, serial shift.
    function automatic reg_act_e pick_act(
        input logic rst,
        input logic load,
        input logic rearm,
        input logic shift_ok
    );
        if (rst)           return ACT_INIT;
        else if (load)     return ACT_LOAD;
        else if (rearm)    return ACT_INIT;
        else if (shift_ok) return ACT_SHIFT;
        else               return ACT_HOLD;
    endfunction

endpackage

// File: rtl/sp_edge_sync.sv
`timescale 1ns/1ps
module sp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    localparam int LAST = STAGES;

    logic [LAST:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[LAST-1:0], async_i};
    end

    assign fall_o = pipe_q[LAST] & ~pipe_q[LAST-1];

    // A detected falling edge lasts exactly one system cycle (R3).
    p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sp_marker_reg.sv
`timescale 1ns/1ps
module sp_marker_reg
    import sp_entry_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_act_e     act_i,
    input  logic [W-1:0] par_d_i,
    input  logic         ser_d_i,
    output logic [W-1:0] word_o,
    output logic         fc_o
);
    // Initial pattern: marker in the top stage, completion stage clear.
    localparam logic [W-1:0] SENTINEL = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] data_q;
    logic         fc_q;

    always_ff @(posedge clk) begin
        unique case (act_i)
            ACT_INIT: begin
                data_q <= SENTINEL;
                fc_q   <= 1'b0;
            end
            ACT_LOAD: begin
                data_q <= par_d_i;
                fc_q   <= 1'b1;
            end
            ACT_SHIFT: {data_q, fc_q} <= {ser_d_i, data_q};
            default: ;
        endcase
    end

    assign word_o = data_q;
    assign fc_o   = fc_q;

    // A full register is never shifted again (R5).
    p_no_shift_when_full_r5: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SHIFT) |-> !fc_q);

endmodule

// File: rtl/sp_xfer_ctl.sv
`timescale 1ns/1ps
module sp_xfer_ctl #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xfer_n_i,
    input  logic         top_empty_i,
    input  logic         full_i,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         wr_o,
    output logic [W-1:0] data_o,
    output logic         done_o,
    output logic         rearm_o
);
    logic         done_q;
    logic         wr_q;
    logic [W-1:0] data_q;
    logic         wr_go;

    assign wr_go = !xfer_n_i && top_empty_i && full_i && !done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            data_q <= '0;
        end else begin
            wr_q <= wr_go;
            if (wr_go)                data_q <= word_i;
            if (wr_go)                done_q <= 1'b1;
            else if (done_q && !load_i) done_q <= 1'b0;
        end
    end

    assign wr_o    = wr_q;
    assign data_o  = data_q;
    assign done_o  = done_q;
    assign rearm_o = done_q && !load_i;

    // One strobe per word, never back to back (R9).
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        wr_q |=> !wr_q);

    // A strobe only follows a cycle with a free top location (R8).
    p_strobe_space_r8: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> ($past(top_empty_i) && !$past(xfer_n_i)));

    // The transfer record survives while load is held (R10).
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done_q && load_i) |=> done_q);

endmodule

// File: rtl/sp_entry_reg.sv
`timescale 1ns/1ps
module sp_entry_reg
    import sp_entry_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] par_d_i,
    input  logic         ser_clk_i,
    input  logic         ser_en_n_i,
    input  logic         ser_d_i,
    input  logic         xfer_n_i,
    input  logic         stk_top_empty_i,
    output logic         full_n_o,
    output logic         stk_wr_o,
    output logic [W-1:0] stk_data_o
);
    logic         ser_fall;
    logic         fc;
    logic         done;
    logic         rearm;
    logic         shift_ok;
    logic [W-1:0] word;
    reg_act_e     act;

    sp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ser_clk_i),
        .fall_o  (ser_fall)
    );

    assign shift_ok = ser_fall && !ser_en_n_i && !fc && !done;
    assign act      = pick_act(rst, load_i, rearm, shift_ok);

    sp_marker_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .par_d_i (par_d_i),
        .ser_d_i (ser_d_i),
        .word_o  (word),
        .fc_o    (fc)
    );

    sp_xfer_ctl #(.W(W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .xfer_n_i    (xfer_n_i),
        .top_empty_i (stk_top_empty_i),
        .full_i      (fc),
        .load_i      (load_i),
        .word_i      (word),
        .wr_o        (stk_wr_o),
        .data_o      (stk_data_o),
        .done_o      (done),
        .rearm_o     (rearm)
    );

    assign full_n_o = ~fc;

    // A parallel load always leaves the register full (R2).
    p_load_sets_full_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !full_n_o);

    // Full clears only after load has been released (R10).
    p_rise_after_release_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(full_n_o) |-> !$past(load_i));

endmodule

// File: tb/sp_entry_reg_tb_top.sv
`timescale 1ns/1ps
module sp_entry_reg_tb_top;
    localparam int W = 4;
    localparam int NVEC = 6;
    localparam logic [W-1:0] PVEC [NVEC] = '{4'hA, 4'h5, 4'hF, 4'h0, 4'h3, 4'hC};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst, load, ser_clk, ser_en_n, ser_d, xfer_man, auto_mode, top_empty;
    logic [W-1:0] par_d, stk_data;
    logic         full_n, stk_wr, xfer_n;

    assign xfer_n = auto_mode ? full_n : xfer_man;

    int n_chk = 0;
    int n_fail = 0;
    int n_strobe = 0;
    logic [W-1:0] last_word = '0;

    sp_entry_reg #(.W(W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .load_i          (load),
        .par_d_i         (par_d),
        .ser_clk_i       (ser_clk),
        .ser_en_n_i      (ser_en_n),
        .ser_d_i         (ser_d),
        .xfer_n_i        (xfer_n),
        .stk_top_empty_i (top_empty),
        .full_n_o        (full_n),
        .stk_wr_o        (stk_wr),
        .stk_data_o      (stk_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (stk_wr === 1'b1) begin
            n_strobe++;
            last_word = stk_data;
        end
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        ser_d = b;
        ser_clk = 1'b1;
        repeat (3) tick();
        ser_clk = 1'b0;
        repeat (4) tick();
    endtask

    task automatic ser_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) ser_bit(w[i]);
    endtask

    task automatic xfer_check(input logic [W-1:0] exp, input string tag);
        xfer_man = 1'b0;
        top_empty = 1'b1;
        tick();
        check(stk_wr === 1'b1 && stk_data === exp, tag, int'(stk_data), int'(exp));
        xfer_man = 1'b1;
        tick();
        check(stk_wr === 1'b0 && full_n === 1'b1, tag, int'({stk_wr, full_n}), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s0;
        rst = 1'b1; load = 1'b0; par_d = '0; ser_clk = 1'b0; ser_en_n = 1'b0;
        ser_d = 1'b0; xfer_man = 1'b1; auto_mode = 1'b0; top_empty = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        check(full_n === 1'b1, "R1 full_n", int'(full_n), 1);
        check(stk_wr === 1'b0, "R1 stk_wr", int'(stk_wr), 0);
        check(stk_data === '0, "R1 stk_data", int'(stk_data), 0);

        // R2 / R7: parallel vectors
        for (int v = 0; v < NVEC; v++) begin
            load = 1'b1;
            par_d = PVEC[v];
            tick();
            load = 1'b0;
            check(full_n === 1'b0, "R2 full after load", int'(full_n), 0);
            xfer_check(PVEC[v], "R7 parallel write");
        end

        // R3 / R6: serial word, first bit to bit 0
        begin
            logic [W-1:0] sw;
            sw = 4'b1101;
            for (int i = 0; i < W - 1; i++) ser_bit(sw[i]);
            check(full_n === 1'b1, "R6 three bits", int'(full_n), 1);
            ser_bit(sw[W-1]);
            check(full_n === 1'b0, "R3 full after four", int'(full_n), 0);
        end
        // R5: extra edges ignored
        ser_bit(1'b0);
        ser_bit(1'b0);
        check(full_n === 1'b0, "R5 still full", int'(full_n), 0);
        xfer_check(4'b1101, "R5 word kept");

        // R4: disabled shifting
        ser_en_n = 1'b1;
        ser_word(4'b1111);
        check(full_n === 1'b1, "R4 disabled", int'(full_n), 1);
        ser_en_n = 1'b0;
        for (int i = 0; i < W - 1; i++) ser_bit(i == 1 || i == 2);
        check(full_n === 1'b1, "R4 three enabled", int'(full_n), 1);
        ser_bit(1'b0);
        xfer_check(4'b0110, "R4 word");

        // R8: stack top busy
        load = 1'b1; par_d = 4'h9; tick(); load = 1'b0;
        xfer_man = 1'b0; top_empty = 1'b0;
        s0 = n_strobe;
        repeat (3) tick();
        check(n_strobe == s0, "R8 blocked", n_strobe - s0, 0);
        top_empty = 1'b1;
        tick();
        check(stk_wr === 1'b1 && stk_data === 4'h9, "R8 write", int'(stk_data), 9);
        xfer_man = 1'b1;
        tick();

        // R9 / R10: held request with load held
        load = 1'b1; par_d = 4'h6; tick();
        xfer_man = 1'b0;
        s0 = n_strobe;
        repeat (5) tick();
        check(n_strobe == s0 + 1, "R9 single write", n_strobe - s0, 1);
        check(last_word === 4'h6, "R7 word", int'(last_word), 6);
        check(full_n === 1'b0, "R10 held", int'(full_n), 0);
        load = 1'b0;
        tick();
        check(full_n === 1'b1, "R10 rearm", int'(full_n), 1);
        tick();
        check(n_strobe == s0 + 1, "R9 no rewrite", n_strobe - s0, 1);
        xfer_man = 1'b1;
        tick();

        // R11: automatic mode
        auto_mode = 1'b1;
        s0 = n_strobe;
        load = 1'b1; par_d = 4'hB; tick(); load = 1'b0;
        repeat (6) tick();
        check(n_strobe == s0 + 1, "R11 parallel count", n_strobe - s0, 1);
        check(last_word === 4'hB, "R11 parallel word", int'(last_word), 11);
        check(full_n === 1'b1, "R11 rearmed", int'(full_n), 1);
        ser_word(4'b0011);
        repeat (4) tick();
        check(n_strobe == s0 + 2, "R11 serial count", n_strobe - s0, 2);
        check(last_word === 4'b0011, "R11 serial word", int'(last_word), 3);
        auto_mode = 1'b0;
        tick();

        // R1: reset in the middle of a serial word
        ser_bit(1'b1);
        ser_bit(1'b1);
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check(full_n === 1'b1, "R1 mid reset", int'(full_n), 1);
        ser_bit(1'b0);
        ser_bit(1'b0);
        ser_bit(1'b0);
        check(full_n === 1'b1, "R1 restart count", int'(full_n), 1);
        ser_bit(1'b1);
        check(full_n === 1'b0, "R1 restart full", int'(full_n), 0);
        xfer_check(4'b1000, "R1 restart word");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule